// File: doc/BRIEF.md
# Quadrature Position Counter with Marker Clear

This block turns a pair of quadrature phase signals into a signed position count. The count goes up or down by one on each legal phase transition. If both phases change in the same sample, the count does not move and a sticky error bit is set.

A separate marker input can zero the count. Each zeroing is reported to a host through a three-step handshake:

1. The block raises a completion flag.
2. The host answers by raising an acknowledge. The block then drops the completion flag.
3. The host releases the acknowledge, and only then does the block accept another marker.

Each channel uses one instance of the block, so independent channels are built by placing several instances.

All asynchronous inputs (both phases, the marker and the host acknowledge) pass through two-flop synchronisers. The marker-enable input is taken as synchronous to the clock. The reset is synchronous and active high. It zeroes the count and all flags and leaves the block ready to accept a marker.

Top module: `quad_marker_counter`

## Requirements
- R1: After reset, `count` is 0, `done_flag` is 0, `phase_err` is 0, and the block is armed.
- R2: Phases are read as {A,B}. Each step along the order 00→10→11→01→00 adds one to `count`. A change on the phase pins shows on `count` three clock edges later.
- R3: Each step along the reverse order 00→01→11→10→00 subtracts one from `count`.
- R4: If A and B both change in one sample, `count` is unchanged and `phase_err` goes to 1. `phase_err` stays at 1 until reset.
- R5: A rising edge on `marker` clears `count` to 0 and sets `done_flag` to 1 when two conditions hold: the block is armed and `marker_en` is 1.
- R6: `ack_seen` follows `host_ack` two clock edges late. While `done_flag` is 1, seeing `ack_seen` at 1 drops `done_flag`.
- R7: A marker edge never clears `count` in either of these periods:
  - while `done_flag` is high;
  - while the acknowledge has not yet been released.
- R8: A marker held high across re-arming causes no further clear. A new rising edge is required.
- R9: A marker edge while `marker_en` is 0 has no effect.
- R10: A count step and a clear in the same cycle leave `count` at 0.
- R11: `count` is two's complement and wraps: 0 minus one gives all ones, and all ones plus one gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Quadrature phase A (asynchronous) |
| phase_b | input | 1 | Quadrature phase B (asynchronous) |
| marker | input | 1 | Marker; its rising edge requests a clear |
| marker_en | input | 1 | Enables marker clears |
| host_ack | input | 1 | Host acknowledge of a completed clear |
| count | output | CNT_W | Signed position count |
| done_flag | output | 1 | Clear completed, waiting for acknowledge |
| ack_seen | output | 1 | Synchronised acknowledge as seen by the logic |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
Forward and reverse phase walks are compared with a count model. A forward walk that is off by one, or that moves the wrong way, shows up as a sign error. A double-phase jump separates a decoder that miscounts an illegal step from one that ignores it correctly.

Marker edges are applied in three situations, each checked for whether a clear occurs:
- in every handshake state;
- with the enable low;
- held high across re-arming.

A phase step landing in the same cycle as a marker edge exposes a wrong priority between clear and count. Walking down from zero and back up checks the wrap.

// File: rtl/quad_marker_counter.sv
module quad_marker_counter #(
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    phase_a,
  input  logic                    phase_b,
  input  logic                    marker,
  input  logic                    marker_en,
  input  logic                    host_ack,
  output logic signed [CNT_W-1:0] count,
  output logic                    done_flag,
  output logic                    ack_seen,
  output logic                    phase_err
);

  localparam logic signed [CNT_W-1:0] ONE = 1;

  typedef enum logic [1:0] {S_ARMED, S_DONE, S_REL} hs_t;
  hs_t st;

  logic [2:0] a_sh, b_sh, m_sh;
  logic [1:0] k_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      b_sh <= '0;
      m_sh <= '0;
      k_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], phase_a};
      b_sh <= {b_sh[1:0], phase_b};
      m_sh <= {m_sh[1:0], marker};
      k_sh <= {k_sh[0], host_ack};
    end
  end

  logic [1:0] prev_pos, cur_pos, delta;
  assign prev_pos = {b_sh[2], a_sh[2] ^ b_sh[2]};
  assign cur_pos  = {b_sh[1], a_sh[1] ^ b_sh[1]};
  assign delta    = cur_pos - prev_pos;

  logic step_up, step_dn, step_bad, m_rise, clr;
  assign step_up  = (delta == 2'd1);
  assign step_dn  = (delta == 2'd3);
  assign step_bad = (delta == 2'd2);
  assign m_rise   = m_sh[1] & ~m_sh[2];
  assign clr      = (st == S_ARMED) & marker_en & m_rise;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (clr)     count <= '0;
    else if (step_up) count <= count + ONE;
    else if (step_dn) count <= count - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)           phase_err <= 1'b0;
    else if (step_bad) phase_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_ARMED;
    else begin
      case (st)
        S_ARMED: if (clr)      st <= S_DONE;
        S_DONE:  if (k_sh[1])  st <= S_REL;
        S_REL:   if (!k_sh[1]) st <= S_ARMED;
        default:               st <= S_ARMED;
      endcase
    end
  end

  assign done_flag = (st == S_DONE);
  assign ack_seen  = k_sh[1];

  // R5
  marker_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARMED && marker_en && m_rise) |=> (count == '0 && done_flag));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    phase_err |=> phase_err);

  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag && ack_seen) |=> !done_flag);

  // R7
  no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_REL && ack_seen) |=> (!done_flag && st == S_REL));

  // R2 R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + ONE ||
              count == $past(count) - ONE));

endmodule

// File: tb/quad_marker_counter_test.sv
module quad_marker_counter_test;
  logic clk = 0, rst = 1;
  logic pa = 0, pb = 0, mk = 0, men = 1, ack = 0;
  logic signed [31:0] count;
  logic done_flag, ack_seen, phase_err;

  quad_marker_counter uut (
    .clk(clk), .rst(rst), .phase_a(pa), .phase_b(pb), .marker(mk),
    .marker_en(men), .host_ack(ack), .count(count), .done_flag(done_flag),
    .ack_seen(ack_seen), .phase_err(phase_err)
  );

  always #4 clk = ~clk;

  typedef struct { int cnt; bit done; bit ack; bit err; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  int m_cnt; bit m_err; int m_st; bit m_pa, m_pb, m_mk;

  function automatic int pos(bit a, bit b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; pa = 0; pb = 0; mk = 0; men = 1; ack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_cnt = 0; m_err = 0; m_st = 0; m_pa = 0; m_pb = 0; m_mk = 0;
  endtask

  task automatic apply(bit a, bit b, bit m, bit en, bit k, string req);
    item_t it;
    int d;
    bit clr;
    @(negedge clk);
    pa = a; pb = b; mk = m; men = en; ack = k;
    d = (pos(a, b) - pos(m_pa, m_pb) + 4) % 4;
    clr = (m_st == 0) && en && m && !m_mk;
    if (clr) begin
      m_cnt = 0; m_st = 1;
    end else if (d == 1) m_cnt = m_cnt + 1;
    else if (d == 3) m_cnt = m_cnt - 1;
    if (d == 2) m_err = 1;
    if (m_st == 1 && k) m_st = 2;
    if (m_st == 2 && !k) m_st = 0;
    m_pa = a; m_pb = b; m_mk = m;
    repeat (4) @(negedge clk);
    it.cnt = m_cnt; it.done = (m_st == 1); it.ack = k; it.err = m_err; it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      checks++;
      if (count !== it.cnt || done_flag !== it.done || ack_seen !== it.ack ||
          phase_err !== it.err) begin
        fails++;
        $display("FAIL %s: count=%0d done=%0b ack=%0b err=%0b expected count=%0d done=%0b ack=%0b err=%0b",
                 it.req, count, done_flag, ack_seen, phase_err,
                 it.cnt, it.done, it.ack, it.err);
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    apply(0, 0, 0, 1, 0, "R1");
    apply(1, 0, 0, 1, 0, "R2");
    apply(1, 1, 0, 1, 0, "R2");
    apply(0, 1, 0, 1, 0, "R2");
    apply(0, 0, 0, 1, 0, "R2");
    apply(1, 0, 0, 1, 0, "R2");
    apply(0, 0, 0, 1, 0, "R3");
    apply(0, 1, 0, 1, 0, "R3");
    apply(1, 1, 0, 1, 0, "R3");
    apply(1, 0, 0, 1, 0, "R3");
    apply(0, 0, 0, 1, 0, "R3");
    apply(0, 1, 0, 1, 0, "R11");
    apply(0, 0, 0, 1, 0, "R11");
    apply(1, 0, 0, 1, 0, "R2");
    apply(1, 1, 0, 1, 0, "R2");
    apply(1, 1, 1, 1, 0, "R5");
    apply(0, 1, 0, 1, 0, "R7");
    apply(0, 1, 1, 1, 0, "R7");
    apply(0, 1, 1, 1, 1, "R6");
    apply(0, 1, 0, 1, 1, "R7");
    apply(0, 1, 1, 1, 1, "R7");
    apply(0, 0, 1, 1, 1, "R7");
    apply(0, 0, 1, 1, 0, "R8");
    apply(0, 0, 0, 0, 0, "R9");
    apply(0, 0, 1, 0, 0, "R9");
    apply(0, 0, 0, 1, 0, "R9");
    apply(1, 0, 1, 1, 0, "R10");
    apply(1, 0, 0, 1, 1, "R6");
    apply(1, 0, 0, 1, 0, "R6");
    apply(0, 1, 0, 1, 0, "R4");
    apply(0, 0, 0, 1, 0, "R4");
    do_reset();
    apply(0, 0, 0, 1, 0, "R1");
    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule